// File: doc/BRIEF.md
# Video Raster Timing Generator

This block keeps the raster position of a tile-based video processor. A dot counter steps through each scan line and a line counter steps through each frame. Both advance only on cycles where a dot enable is high. When the line counter reaches the first vertical-blank line, the block sets a vertical-blank interrupt flag and emits a one-cycle end-of-frame strobe. If the CPU has enabled it, the block also raises a one-cycle interrupt request. The flag is cleared when the frame wraps. A frame counter counts completed frames.

The CPU reaches the block through a write port, which only sets or clears the interrupt-enable bit, and through a combinational read port. The read port returns two status bytes. One carries the interrupt flag together with open-bus address bits. The other reports vertical blank and a horizontal-blank window that wraps across the end and the start of each line. Reading either byte changes no state.

Top module: `raster_timer`

## Requirements
- R1: The dot counter counts 0 to 340 on enabled cycles. After 340 it returns to 0 and the line counter advances by one.
- R2: The line counter counts 0 to 261. When it would pass 261 it returns to 0 and the frame counter increments by one.
- R3: When dot_en is low, the dot, line and frame counters hold their values.
- R4: On the enabled edge where the line counter becomes 225 (dot 0), the interrupt flag is set and frame_end is high for exactly one cycle.
- R5: irq is a one-cycle pulse at the same point as R4. It is raised only if the enable bit is 1. The enable bit is bit 7 of the last wr_data written with wr_en high and wr_addr = 0x4200.
- R6: The interrupt flag is cleared on the edge where the line counter wraps from 261 to 0.
- R7: A read with rd_addr = 0x4210 returns the flag in bit 7 and rd_addr[14:12] in bits 6:4. Bits 3:0 read 0. At that address this gives 0xC0 with the flag set and 0x40 with it clear.
- R8: A read with rd_addr = 0x4212 returns bit 7 = 1 while the line is 225 or greater. Bit 6 = 1 while the dot is 289 or greater, or 21 or less. All other bits, and all other addresses, read 0.
- R9: After reset, dot, line and frame are 0, the flag is clear, the enable bit is 0, and irq and frame_end are low.
- R10: Reading the status bytes has no side effect. In particular, it does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Advance the raster by one dot this cycle |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 16 | CPU read address for the status bytes |
| rd_data | output | 8 | Status byte for rd_addr (combinational) |
| dot | output | 9 | Dot within line |
| line | output | 9 | Line within frame |
| frame | output | 16 | Frame counter |
| irq | output | 1 | One-cycle interrupt request |
| frame_end | output | 1 | One-cycle end-of-frame strobe |

## Verification
The main function is exercised in four ways. The dot enable held low shows that the counters freeze. A single full line shows the dot-to-line carry. A whole frame with the dot enable always high shows the line-225 set point and the 261-to-0 wrap. A second frame with the interrupt disabled shows that the request is gated while the flag and strobe still occur. Dots 21, 22, 288 and 289 are probed so that an off-by-one on either edge of the wrapped horizontal-blank window is caught. Repeated status reads while the flag is set tell a side-effect-free read apart from a read-to-clear one.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int VBLANK_LINE     = 225,
  parameter int HBLANK_START    = 289,
  parameter int HBLANK_END      = 21,
  parameter int FRAME_W         = 16,
  parameter logic [15:0] IRQ_EN_ADDR = 16'h4200,
  parameter logic [15:0] STAT_A_ADDR = 16'h4210,
  parameter logic [15:0] STAT_B_ADDR = 16'h4212
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dot_en,
  input  logic               wr_en,
  input  logic [15:0]        wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [15:0]        rd_addr,
  output logic [7:0]         rd_data,
  output logic [8:0]         dot,
  output logic [8:0]         line,
  output logic [FRAME_W-1:0] frame,
  output logic               irq,
  output logic               frame_end
);
  localparam logic [8:0] DOT_LAST  = 9'(DOTS_PER_LINE - 1);
  localparam logic [8:0] LINE_LAST = 9'(LINES_PER_FRAME - 1);
  localparam logic [8:0] VB_LINE   = 9'(VBLANK_LINE);
  localparam logic [8:0] HB_START  = 9'(HBLANK_START);
  localparam logic [8:0] HB_END    = 9'(HBLANK_END);

  logic       vb_flag, irq_en;
  logic       line_end, frame_wrap;
  logic [8:0] line_nxt;
  logic       vblank, hblank;

  assign line_end   = dot_en && (dot == DOT_LAST);
  assign frame_wrap = line_end && (line == LINE_LAST);
  assign line_nxt   = frame_wrap ? 9'd0 : line + 9'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot       <= '0;
      line      <= '0;
      frame     <= '0;
      vb_flag   <= 1'b0;
      irq_en    <= 1'b0;
      irq       <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      irq       <= 1'b0;
      frame_end <= 1'b0;
      if (wr_en && wr_addr == IRQ_EN_ADDR)
        irq_en <= wr_data[7];
      if (dot_en)
        dot <= line_end ? 9'd0 : dot + 9'd1;
      if (line_end) begin
        line <= line_nxt;
        if (frame_wrap) begin
          frame   <= frame + 1'b1;
          vb_flag <= 1'b0;
        end else if (line_nxt == VB_LINE) begin
          vb_flag   <= 1'b1;
          frame_end <= 1'b1;
          irq       <= irq_en;
        end
      end
    end
  end

  assign vblank = line >= VB_LINE;
  assign hblank = (dot >= HB_START) || (dot <= HB_END);

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == STAT_A_ADDR)
      rd_data = {vb_flag, rd_addr[14:12], 4'h0};
    else if (rd_addr == STAT_B_ADDR)
      rd_data = {vblank, hblank, 6'h00};
  end
endmodule

module raster_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dot_en,
  input logic [8:0] dot,
  input logic [8:0] line,
  input logic       irq,
  input logic       frame_end,
  input logic       vb_flag
);
  p_dot_range_r1: assert property (@(posedge clk) disable iff (!rst_n) dot <= 9'd340);
  p_line_range_r2: assert property (@(posedge clk) disable iff (!rst_n) line <= 9'd261);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> $stable(dot) && $stable(line));
  p_strobe_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> line == 9'd225 && dot == 9'd0 && vb_flag);
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
  p_irq_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> frame_end);
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vb_flag) |-> line == 9'd0 && dot == 9'd0);
endmodule

bind raster_timer raster_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .dot(dot), .line(line),
  .irq(irq), .frame_end(frame_end), .vb_flag(vb_flag)
);

// File: tb/raster_timer_tb.sv
module raster_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dot_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic [8:0]  dot, line;
  logic [15:0] frame;
  logic        irq, frame_end;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  raster_timer dut_i (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dot(dot),
    .line(line), .frame(frame), .irq(irq), .frame_end(frame_end)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output int v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dot_en = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic wr_irq_en(input logic [7:0] d);
    wr_en = 1'b1; wr_addr = 16'h4200; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    chk("R9 dot", dot, 0);
    chk("R9 line", line, 0);
    chk("R9 frame", frame, 0);
    chk("R9 irq", irq, 0);
    chk("R9 frame_end", frame_end, 0);
    rd(16'h4210, v); chk("R9 flag clear", v, 8'h40);
    rd(16'h4212, v); chk("R8 status B at dot 0", v, 8'h40);
    rd(16'h1234, v); chk("R8 other address", v, 0);
  endtask

  task automatic t_hold();
    dot_en = 1'b0;
    step(10);
    chk("R3 dot held", dot, 0);
    chk("R3 line held", line, 0);
  endtask

  task automatic t_line();
    int v;
    dot_en = 1'b1;
    step(21); rd(16'h4212, v); chk("R8 hblank dot 21", v, 8'h40);
    step(1);  rd(16'h4212, v); chk("R8 active dot 22", v, 8'h00);
    step(266); chk("R1 dot 288", dot, 288);
    rd(16'h4212, v); chk("R8 active dot 288", v, 8'h00);
    step(1);  rd(16'h4212, v); chk("R8 hblank dot 289", v, 8'h40);
    step(51); chk("R1 dot 340", dot, 340); chk("R1 line 0", line, 0);
    step(1);  chk("R1 dot wrap", dot, 0); chk("R1 line advance", line, 1);
    dot_en = 1'b0;
    step(3);  chk("R3 hold after wrap", dot, 0);
  endtask

  task automatic t_frame_irq();
    int v;
    do_reset();
    wr_irq_en(8'h80);
    dot_en = 1'b1;
    step(225 * 341 - 1);
    chk("R4 before set line", line, 224);
    chk("R5 no early irq", irq, 0);
    rd(16'h4210, v); chk("R7 flag not yet", v, 8'h40);
    step(1);
    chk("R4 line 225", line, 225);
    chk("R4 frame_end pulse", frame_end, 1);
    chk("R5 irq pulse", irq, 1);
    rd(16'h4210, v); chk("R7 flag set", v, 8'hC0);
    rd(16'h4212, v); chk("R8 vblank and hblank", v, 8'hC0);
    step(1);
    chk("R4 frame_end one cycle", frame_end, 0);
    chk("R5 irq one cycle", irq, 0);
    for (int i = 0; i < 5; i++) begin
      rd(16'h4210, v); step(1);
    end
    rd(16'h4210, v); chk("R10 flag kept after reads", v, 8'hC0);
    step(37 * 341 - 7);
    chk("R2 line 261", line, 261); chk("R1 dot 340 end", dot, 340);
    rd(16'h4210, v); chk("R6 flag before wrap", v, 8'hC0);
    step(1);
    chk("R2 line wrap", line, 0);
    chk("R2 frame count", frame, 1);
    rd(16'h4210, v); chk("R6 flag cleared", v, 8'h40);
    rd(16'h4212, v); chk("R8 no vblank line 0", v, 8'h40);
  endtask

  task automatic t_frame_noirq();
    int v;
    wr_irq_en(8'h7F);
    step(225 * 341 - 1);
    chk("R4 line 225 frame 2", line, 225);
    chk("R4 frame_end without enable", frame_end, 1);
    chk("R5 irq gated by enable", irq, 0);
    rd(16'h4210, v); chk("R7 flag set frame 2", v, 8'hC0);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_line();
    t_frame_irq();
    t_frame_noirq();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule